// File: doc/BRIEF.md
# Two-Stage Priority Stream Arbiter

This block decides which of eight transfer streams may start its next transfer on each of two master ports. One port carries memory-side accesses and the other carries peripheral-side accesses. Each stream picks its request from one of eight peripheral request lines through a 3-bit channel select. A stream takes part in arbitration only when it is enabled and its selected line is high.

The winner is chosen in two stages. The stream with the highest programmed 2-bit priority level wins first. If several streams share that level, the stream with the lowest index wins. Each port keeps its grant registered while its transfer runs. The port picks again only when it is idle or when its transfer reports done in that cycle, and the new grant appears one clock later.

Both ports share one request picture, but each has its own busy/done handshake. The two ports can therefore hold different winners at the same time.

Top module: `stream_prio_arbiter`

## Requirements
- R1: Stream s takes its request from `chan_req[strm_chsel[3s+2:3s]]`, so any stream can be tied to any of the eight request lines.
- R2: The priority field of stream s is `strm_prio[2s+1:2s]`, with 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low.
- R3: Among eligible streams, one with a strictly higher priority level wins over every stream with a lower level, whatever their indices.
- R4: Among eligible streams that share the top level, the one with the lowest index wins.
- R5: Port 0 (memory) and port 1 (peripheral) arbitrate independently. A done on one port never changes the grant of the other port.
- R6: A port picks a new winner only while it holds no grant, or in a cycle where its `port_done` bit is high. The result shows on the outputs on the next clock. While a grant is held and done is low, the grant stays unchanged, even if its request drops.
- R7: A stream whose `strm_en` bit is low, or whose selected request line is low, is never granted.
- R8: When a port picks and no stream is eligible, the port's grant-valid output goes low and its grant vector is all zeros.
- R9: Changes to priority or channel-select settings affect only the next pick. They do not alter a grant being held.
- R10: A synchronous active-low reset clears every grant and leaves both ports idle.
- R11: Each port's grant vector is one-hot while its valid is high. Its grant index equals the position of the set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_req | input | 8 | Peripheral request lines, one per channel |
| strm_en | input | 8 | Per-stream enable |
| strm_prio | input | 16 | Per-stream 2-bit priority level, stream s at bits 2s+1:2s |
| strm_chsel | input | 24 | Per-stream 3-bit channel select, stream s at bits 3s+2:3s |
| port_done | input | 2 | Transfer-done pulse per port (bit 0 memory, bit 1 peripheral) |
| port_gnt_vld | output | 2 | Grant valid per port |
| port_gnt | output | 16 | One-hot grant per port, port p at bits 8p+7:8p |
| port_gnt_idx | output | 6 | Encoded granted stream per port, port p at bits 3p+2:3p |

## Verification
On every cycle, the assertions check the shape of each port's output. The grant must be one-hot. The grant index must match the set bit, and valid must agree with a non-empty vector. They also check that a held grant stays put while done is low, that a fresh grant only ever names an enabled stream, and that reset empties the port. The actual ranking cannot be shown by the per-cycle checks and is left to the bench scenarios. That covers the order of the four levels, the lowest-index tie-break, the channel-select mapping and the way two ports separate when only one sees done.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NUM_STREAMS = 8;
    localparam int NUM_CHAN    = 8;
    localparam int PRIO_W      = 2;
    localparam int NUM_PORTS   = 2;

    typedef enum logic [PRIO_W-1:0] {
        LVL_LOW   = 2'b00,
        LVL_MED   = 2'b01,
        LVL_HIGH  = 2'b10,
        LVL_VHIGH = 2'b11
    } lvl_e;
endpackage

// File: rtl/stream_req_sel.sv
module stream_req_sel #(
    parameter int N    = 8,
    parameter int C    = 8,
    parameter int CH_W = $clog2(C)
) (
    input  logic [C-1:0]      chan_req,
    input  logic [N-1:0]      en,
    input  logic [N*CH_W-1:0] chsel,
    output logic [N-1:0]      active
);
    for (genvar s = 0; s < N; s++) begin : g_strm
        assign active[s] = en[s] & chan_req[chsel[s*CH_W +: CH_W]];
    end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N     = 8,
    parameter int PW    = 2,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]    active,
    input  logic [N*PW-1:0] prio,
    output logic            found,
    output logic [IDX_W-1:0] win
);
    logic [PW-1:0] best;

    // Linear scan: strict '>' keeps the lower index on equal levels.
    always_comb begin
        found = 1'b0;
        best  = '0;
        win   = '0;
        for (int i = 0; i < N; i++) begin
            if (active[i] && (!found || prio[i*PW +: PW] > best)) begin
                found = 1'b1;
                best  = prio[i*PW +: PW];
                win   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/port_grant.sv
module port_grant #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             found,
    input  logic [IDX_W-1:0] win,
    output logic             vld,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } gstate_t;

    gstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.vld || done) begin
            st_d.vld = found;
            st_d.idx = found ? win : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        gnt = '0;
        if (st_q.vld) begin
            gnt[st_q.idx] = 1'b1;
        end
    end

    assign vld = st_q.vld;
    assign idx = st_q.idx;
endmodule

// File: rtl/stream_prio_arbiter.sv
module stream_prio_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_STREAMS = arb_pkg::NUM_STREAMS,
    parameter int NUM_CHAN    = arb_pkg::NUM_CHAN,
    parameter int PRIO_W      = arb_pkg::PRIO_W,
    parameter int NUM_PORTS   = arb_pkg::NUM_PORTS,
    localparam int CH_W       = $clog2(NUM_CHAN),
    localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CHAN-1:0]           chan_req,
    input  logic [NUM_STREAMS-1:0]        strm_en,
    input  logic [NUM_STREAMS*PRIO_W-1:0] strm_prio,
    input  logic [NUM_STREAMS*CH_W-1:0]   strm_chsel,
    input  logic [NUM_PORTS-1:0]          port_done,
    output logic [NUM_PORTS-1:0]          port_gnt_vld,
    output logic [NUM_PORTS*NUM_STREAMS-1:0] port_gnt,
    output logic [NUM_PORTS*IDX_W-1:0]    port_gnt_idx
);
    logic [NUM_STREAMS-1:0] active;
    logic                   found;
    logic [IDX_W-1:0]       win;

    stream_req_sel #(.N(NUM_STREAMS), .C(NUM_CHAN), .CH_W(CH_W)) u_sel (
        .chan_req (chan_req),
        .en       (strm_en),
        .chsel    (strm_chsel),
        .active   (active)
    );

    prio_pick #(.N(NUM_STREAMS), .PW(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .active (active),
        .prio   (strm_prio),
        .found  (found),
        .win    (win)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_grant #(.N(NUM_STREAMS), .IDX_W(IDX_W)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .done  (port_done[p]),
            .found (found),
            .win   (win),
            .vld   (port_gnt_vld[p]),
            .gnt   (port_gnt[p*NUM_STREAMS +: NUM_STREAMS]),
            .idx   (port_gnt_idx[p*IDX_W +: IDX_W])
        );
    end
endmodule

// File: rtl/arb_port_chk.sv
module arb_port_chk #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [N-1:0]  en,
    input logic          vld,
    input logic [N-1:0]  gnt,
    input logic [IW-1:0] idx
);
    logic [N-1:0] en_prev;
    logic         free_prev;

    always_ff @(posedge clk) begin
        en_prev <= en;
        if (!rst_n) free_prev <= 1'b1;
        else        free_prev <= !vld || done;
    end

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_idx_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> gnt[idx]);

    p_vld_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vld == (gnt != '0));

    // R9 is covered as well: settings may change, the held grant may not.
    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !done) |=> (vld && $stable(idx)));

    p_grant_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && free_prev) |-> en_prev[idx]);

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!vld && gnt == '0));
endmodule

bind stream_prio_arbiter arb_port_chk #(.N(NUM_STREAMS), .IW(IDX_W)) u_chk_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (port_done[0]),
    .en    (strm_en),
    .vld   (port_gnt_vld[0]),
    .gnt   (port_gnt[0 +: NUM_STREAMS]),
    .idx   (port_gnt_idx[0 +: IDX_W])
);

bind stream_prio_arbiter arb_port_chk #(.N(NUM_STREAMS), .IW(IDX_W)) u_chk_per (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (port_done[1]),
    .en    (strm_en),
    .vld   (port_gnt_vld[1]),
    .gnt   (port_gnt[NUM_STREAMS +: NUM_STREAMS]),
    .idx   (port_gnt_idx[IDX_W +: IDX_W])
);

// File: tb/sim_stream_prio_arbiter.sv
`timescale 1ns/1ps
module sim_stream_prio_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  chan_req;
    logic [7:0]  strm_en;
    logic [15:0] strm_prio;
    logic [23:0] strm_chsel;
    logic [1:0]  port_done;
    logic [1:0]  port_gnt_vld;
    logic [15:0] port_gnt;
    logic [5:0]  port_gnt_idx;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    stream_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .strm_en(strm_en),
        .strm_prio(strm_prio), .strm_chsel(strm_chsel), .port_done(port_done),
        .port_gnt_vld(port_gnt_vld), .port_gnt(port_gnt), .port_gnt_idx(port_gnt_idx)
    );

    localparam logic [23:0] IDENT = 24'hFAC688;  // stream s -> channel s

    typedef struct packed {
        logic [7:0]  en;
        logic [7:0]  req;
        logic [15:0] prio;
        logic [23:0] chsel;
        logic        vld;
        logic [2:0]  idx;
        logic [47:0] tag;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{8'hFF, 8'h00, 16'h0000, IDENT,    1'b0, 3'd0, "R8"},
        '{8'hFF, 8'hFF, 16'h0000, IDENT,    1'b1, 3'd0, "R4"},
        '{8'hFF, 8'h14, 16'h0000, IDENT,    1'b1, 3'd2, "R4"},
        '{8'hFF, 8'hFF, 16'h0C00, IDENT,    1'b1, 3'd5, "R3"},
        '{8'hFF, 8'hFF, 16'h2084, IDENT,    1'b1, 3'd3, "R3 R4"},
        '{8'hF7, 8'hFF, 16'h2084, IDENT,    1'b1, 3'd6, "R7"},
        '{8'hFF, 8'hF7, 16'h2084, IDENT,    1'b1, 3'd6, "R7"},
        '{8'hFF, 8'h01, 16'h2084, 24'h0,    1'b1, 3'd3, "R1"},
        '{8'hFF, 8'h02, 16'h2084, 24'h0,    1'b0, 3'd0, "R1"},
        '{8'hFF, 8'h04, 16'h0000, 24'h400000, 1'b1, 3'd7, "R1"},
        '{8'hFF, 8'h03, 16'h0004, IDENT,    1'b1, 3'd1, "R2"},
        '{8'hFF, 8'h03, 16'h0006, IDENT,    1'b1, 3'd0, "R2"},
        '{8'hFF, 8'h03, 16'h000E, IDENT,    1'b1, 3'd1, "R2"},
        '{8'h00, 8'hFF, 16'h2084, IDENT,    1'b0, 3'd0, "R7"},
        '{8'hFF, 8'h80, 16'h0000, IDENT,    1'b1, 3'd7, "R4"}
    };

    task automatic chk(input int p, input logic ev, input logic [2:0] ei, input string tag);
        logic       av;
        logic [7:0] ag, eg;
        logic [2:0] ai;
        av = port_gnt_vld[p];
        ag = port_gnt[p*8 +: 8];
        ai = port_gnt_idx[p*3 +: 3];
        eg = ev ? (8'h01 << ei) : 8'h00;
        checks++;
        if (av !== ev || ag !== eg || (ev && ai !== ei)) begin
            failures++;
            $display("FAIL %s port%0d: vld=%b gnt=%h idx=%0d expected vld=%b gnt=%h idx=%0d",
                     tag, p, av, ag, ai, ev, eg, ei);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; chan_req = '1; strm_en = '1; strm_prio = '0;
        strm_chsel = IDENT; port_done = 2'b00;
        repeat (3) cyc();
        chk(0, 1'b0, 3'd0, "R10 reset");
        chk(1, 1'b0, 3'd0, "R10 reset");
        @(negedge clk); rst_n = 1'b1;

        // table walk, each pick forced by done on both ports
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            strm_en = VEC[v].en; chan_req = VEC[v].req;
            strm_prio = VEC[v].prio; strm_chsel = VEC[v].chsel;
            port_done = 2'b11;
            cyc();
            chk(0, VEC[v].vld, VEC[v].idx, $sformatf("%s R11 vec%0d", VEC[v].tag, v));
            chk(1, VEC[v].vld, VEC[v].idx, $sformatf("%s R11 vec%0d", VEC[v].tag, v));
        end

        // R6: grant held while busy
        @(negedge clk);
        strm_en = '1; chan_req = 8'h14; strm_prio = '0; strm_chsel = IDENT; port_done = 2'b11;
        cyc();
        chk(0, 1'b1, 3'd2, "R6 setup");
        @(negedge clk);
        port_done = 2'b00; chan_req = 8'hFF; strm_prio = 16'h0C00;
        cyc();
        chk(0, 1'b1, 3'd2, "R6 hold");
        chk(1, 1'b1, 3'd2, "R6 hold");
        // R9: settings change during a held grant
        @(negedge clk);
        strm_chsel = 24'h0; chan_req = 8'h01; strm_prio = 16'hC000;
        cyc();
        chk(0, 1'b1, 3'd2, "R9 cfg change");
        @(negedge clk);
        chan_req = 8'h00;
        cyc();
        chk(1, 1'b1, 3'd2, "R6 request dropped");
        // R5: done on memory port only
        @(negedge clk);
        chan_req = 8'hFF; strm_chsel = IDENT; strm_prio = 16'h0C00; port_done = 2'b01;
        cyc();
        chk(0, 1'b1, 3'd5, "R5 mem repick");
        chk(1, 1'b1, 3'd2, "R5 per untouched");
        @(negedge clk);
        port_done = 2'b10;
        cyc();
        chk(0, 1'b1, 3'd5, "R5 mem untouched");
        chk(1, 1'b1, 3'd5, "R5 per repick");
        // R10: reset while grants are held
        @(negedge clk);
        port_done = 2'b00; rst_n = 1'b0;
        cyc();
        chk(0, 1'b0, 3'd0, "R10 mid reset");
        chk(1, 1'b0, 3'd0, "R10 mid reset");
        @(negedge clk); rst_n = 1'b1;
        cyc();
        chk(0, 1'b1, 3'd5, "R6 idle pick");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule